// File: doc/BRIEF.md
# Multiplexed-Bus Address Latch and Memory Select Decoder

This block sits between a processor with a shared address/data port and three external memories: a program ROM, a data ROM and a data RAM. During the address phase of a bus cycle, the latch strobe `ale` is high. The low address byte on `ad_lo` then passes straight through to the address output. The byte is also held, so it stays on `addr[7:0]` after the strobe falls and the port carries data. The held byte joins the high address port `a_hi` to form the 16-bit address `addr`.

The strobe lines are sorted into a bus phase with four named values:

- `PH_IDLE`: no strobe is low.
- `PH_FETCH`: `psen_n` is low. This takes priority over the data strobes.
- `PH_DREAD`: `rd_n` is low.
- `PH_DWRITE`: only `wr_n` is low.

The phase changes combinationally with the strobes. Every phase can move directly to every other. The phase, the two top address bits and two mode inputs then choose at most one active-low chip select and the output and write enables.

The two mode inputs work as follows:

- `shared_rom`: one program ROM serves both code and data. Its output enable is the AND of the two active-low read strobes.
- `win_mode`: data accesses are narrowed to a single 4K window at 3000H–3FFFH, with a select of its own.

Top module: `mux_bus_mem_decode`

## Requirements
- R1: While `ale` is high, `addr[7:0]` equals `ad_lo` in the same cycle.
- R2: While `ale` is low, `addr[7:0]` keeps the value `ad_lo` had at the last rising clock edge where `ale` was high. Reset clears this held byte to 00H.
- R3: `addr` equals {`a_hi`, low byte}.
- R4: `dram_cs_n` is low only in a data phase (`rd_n` or `wr_n` low, `psen_n` high) with `win_mode`=0 and `addr[15:14]`=2'b10.
- R5: `drom_cs_n` is low only in a data phase with `win_mode`=0, `shared_rom`=0 and `addr[15:14]`=2'b00.
- R6: `prom_cs_n` is low whenever `psen_n` is low, for any address. While `psen_n` is low, every other select is high.
- R7: `mem_oe_n` equals `rd_n`. With `shared_rom`=0, `prom_oe_n` equals `psen_n`.
- R8: With `shared_rom`=1, `prom_oe_n` is `psen_n` AND `rd_n`. A data phase with `win_mode`=0 and `addr[15:14]`=2'b00 selects `prom_cs_n`.
- R9: With `win_mode`=1, `win_cs_n` is low only in a data phase with `addr[15:12]`=4'b0011. No other select is low in a data phase.
- R10: `mem_we_n` is low only when `wr_n` is low and `dram_cs_n` or `win_cs_n` is low. Writes to ROM space leave it high.
- R11: At most one chip select is low. None is low when `psen_n`, `rd_n` and `wr_n` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the held address byte |
| rst_n | input | 1 | Active-low reset; clears the held byte |
| ale | input | 1 | Address latch strobe, active high |
| ad_lo | input | 8 | Shared address/data port (low address byte) |
| a_hi | input | 8 | High address byte |
| psen_n | input | 1 | Program-store enable, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| shared_rom | input | 1 | One ROM serves code and data |
| win_mode | input | 1 | Use the 4K window decode for data |
| addr | output | 16 | Full memory address |
| prom_cs_n | output | 1 | Program ROM select |
| prom_oe_n | output | 1 | Program ROM output enable |
| drom_cs_n | output | 1 | Data ROM select |
| dram_cs_n | output | 1 | Data RAM select |
| win_cs_n | output | 1 | Window block select |
| mem_oe_n | output | 1 | Data memory output enable |
| mem_we_n | output | 1 | Data memory write enable |

## Verification
A held byte that is captured wrongly shows up on `addr[7:0]` in the first cycle after `ale` falls. It stays wrong until `ale` rises again, so the bench checks the address right after the strobe drops. A wrong phase or bank decision shows as a wrong or doubled select in the same cycle as the strobe that caused it. The sweep covers every high byte under every strobe pattern and every mode pair, so each such error is seen within one bus cycle of being provoked.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FETCH  = 2'd1,
        PH_DREAD  = 2'd2,
        PH_DWRITE = 2'd3
    } bus_phase_e;

    typedef struct packed {
        logic prom;
        logic drom;
        logic dram;
        logic win;
    } sel_t;
endpackage

// File: rtl/mbd_addr_hold.sv
module mbd_addr_hold #(
    parameter int LO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ale,
    input  logic [LO_W-1:0] ad_lo,
    output logic [LO_W-1:0] lo_addr
);
    logic [LO_W-1:0] held_q;

    // capture every cycle the strobe is high; hold while it is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   held_q <= '0;
        else if (ale) held_q <= ad_lo;
    end

    // transparent path while the strobe is high
    assign lo_addr = ale ? ad_lo : held_q;
endmodule

// File: rtl/mbd_phase.sv
module mbd_phase
    import mbd_pkg::*;
(
    input  logic       psen_n,
    input  logic       rd_n,
    input  logic       wr_n,
    output bus_phase_e phase
);
    // code fetch outranks data strobes; read outranks write
    always_comb begin
        if (!psen_n)    phase = PH_FETCH;
        else if (!rd_n) phase = PH_DREAD;
        else if (!wr_n) phase = PH_DWRITE;
        else            phase = PH_IDLE;
    end
endmodule

// File: rtl/mbd_space_decode.sv
module mbd_space_decode
    import mbd_pkg::*;
#(
    parameter int               BANK_W   = 2,
    parameter int               WIN_W    = 4,
    parameter logic [BANK_W-1:0] RAM_BANK = 2'b10,
    parameter logic [BANK_W-1:0] ROM_BANK = 2'b00,
    parameter logic [WIN_W-1:0]  WIN_TAG  = 4'b0011
) (
    input  bus_phase_e        phase,
    input  logic [WIN_W-1:0]  top_bits,
    input  logic              shared_rom,
    input  logic              win_mode,
    output sel_t              sel
);
    localparam int SHIFT = WIN_W - BANK_W;

    logic [BANK_W-1:0] bank;
    logic              in_win;
    logic              data_ph;

    assign bank    = top_bits[WIN_W-1 -: BANK_W];
    assign in_win  = (top_bits == WIN_TAG);
    assign data_ph = (phase == PH_DREAD) || (phase == PH_DWRITE);

    always_comb begin
        sel = '0;
        unique case (phase)
            PH_IDLE:  sel = '0;
            PH_FETCH: sel.prom = 1'b1;
            PH_DREAD, PH_DWRITE: begin
                if (win_mode) begin
                    sel.win = in_win;
                end else begin
                    sel.dram = (bank == RAM_BANK);
                    if (bank == ROM_BANK) begin
                        if (shared_rom) sel.prom = data_ph;
                        else            sel.drom = data_ph;
                    end
                end
            end
            default:  sel = '0;
        endcase
    end

    if (SHIFT < 0) begin : g_bad_width
        initial $error("WIN_W must be at least BANK_W");
    end
endmodule

// File: rtl/mux_bus_mem_decode.sv
module mux_bus_mem_decode
    import mbd_pkg::*;
#(
    parameter int LO_W   = 8,
    parameter int HI_W   = 8,
    parameter int BANK_W = 2,
    parameter int WIN_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ale,
    input  logic [LO_W-1:0]      ad_lo,
    input  logic [HI_W-1:0]      a_hi,
    input  logic                 psen_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 shared_rom,
    input  logic                 win_mode,
    output logic [LO_W+HI_W-1:0] addr,
    output logic                 prom_cs_n,
    output logic                 prom_oe_n,
    output logic                 drom_cs_n,
    output logic                 dram_cs_n,
    output logic                 win_cs_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n
);
    localparam int AW = LO_W + HI_W;

    logic [LO_W-1:0] lo_addr;
    bus_phase_e      phase;
    sel_t            sel;

    mbd_addr_hold #(.LO_W(LO_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .ale     (ale),
        .ad_lo   (ad_lo),
        .lo_addr (lo_addr)
    );

    mbd_phase u_phase (
        .psen_n (psen_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .phase  (phase)
    );

    mbd_space_decode #(.BANK_W(BANK_W), .WIN_W(WIN_W)) u_dec (
        .phase      (phase),
        .top_bits   (a_hi[HI_W-1 -: WIN_W]),
        .shared_rom (shared_rom),
        .win_mode   (win_mode),
        .sel        (sel)
    );

    assign addr = {a_hi, lo_addr};

    always_comb begin
        prom_cs_n = ~sel.prom;
        drom_cs_n = ~sel.drom;
        dram_cs_n = ~sel.dram;
        win_cs_n  = ~sel.win;
        mem_oe_n  = rd_n;
        prom_oe_n = shared_rom ? (psen_n & rd_n) : psen_n;
        mem_we_n  = ~(~wr_n & (sel.dram | sel.win));
    end

    logic unused_ok;
    assign unused_ok = ^addr[AW-1:0];
endmodule

// File: rtl/mbd_checker.sv
module mbd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ale,
    input logic        psen_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic        shared_rom,
    input logic [15:0] addr,
    input logic        prom_cs_n,
    input logic        prom_oe_n,
    input logic        drom_cs_n,
    input logic        dram_cs_n,
    input logic        win_cs_n,
    input logic        mem_we_n
);
    // R11
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~prom_cs_n, ~drom_cs_n, ~dram_cs_n, ~win_cs_n}) <= 1);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psen_n && rd_n && wr_n) |-> (prom_cs_n && drom_cs_n && dram_cs_n && win_cs_n));

    // R10
    rom_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!wr_n && prom_cs_n && drom_cs_n));

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && $past(!ale)) |-> $stable(addr[7:0]));

    // R8
    shared_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_rom && (!psen_n || !rd_n)) |-> !prom_oe_n);

    // R4
    ram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cs_n |-> (addr[15:14] == 2'b10 && psen_n));

    // R9
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_cs_n |-> (addr[15:12] == 4'b0011));
endmodule

bind mux_bus_mem_decode mbd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ale        (ale),
    .psen_n     (psen_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .shared_rom (shared_rom),
    .addr       (addr),
    .prom_cs_n  (prom_cs_n),
    .prom_oe_n  (prom_oe_n),
    .drom_cs_n  (drom_cs_n),
    .dram_cs_n  (dram_cs_n),
    .win_cs_n   (win_cs_n),
    .mem_we_n   (mem_we_n)
);

// File: tb/mux_bus_mem_decode_tb.sv
`timescale 1ns/1ps
module mux_bus_mem_decode_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic [7:0]  ad_lo = 8'h00;
    logic [7:0]  a_hi = 8'h00;
    logic        psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        shared_rom = 1'b0, win_mode = 1'b0;
    logic [15:0] addr;
    logic        prom_cs_n, prom_oe_n, drom_cs_n, dram_cs_n, win_cs_n, mem_oe_n, mem_we_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mux_bus_mem_decode u_dut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ad_lo(ad_lo), .a_hi(a_hi),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .shared_rom(shared_rom), .win_mode(win_mode), .addr(addr),
        .prom_cs_n(prom_cs_n), .prom_oe_n(prom_oe_n), .drom_cs_n(drom_cs_n),
        .dram_cs_n(dram_cs_n), .win_cs_n(win_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (hi=%h psen_n=%b rd_n=%b wr_n=%b shared=%b win=%b)",
                     tag, act, exp, a_hi, psen_n, rd_n, wr_n, shared_rom, win_mode);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [3:0] exp_sel;
        logic [2:0] exp_en;
        logic       code, data, shr, win;
        logic [1:0] bank;

        // reset state: held byte cleared, nothing selected (R2, R11)
        a_hi  = 8'h12;
        ad_lo = 8'hEE;
        repeat (3) @(negedge clk);
        #2;
        check("R2 reset low byte", {8'h00, addr[7:0]}, 16'h0000);
        check("R11 reset selects", {12'h0, prom_cs_n, drom_cs_n, dram_cs_n, win_cs_n}, 16'h000F);
        @(negedge clk);
        rst_n = 1'b1;

        // transparent then hold (R1, R2)
        @(negedge clk);
        ale   = 1'b1;
        ad_lo = 8'hA5;
        #2;
        check("R1 transparent", {8'h00, addr[7:0]}, 16'h00A5);
        @(negedge clk);
        ale   = 1'b0;
        ad_lo = 8'h3C;
        #2;
        check("R2 held after fall", {8'h00, addr[7:0]}, 16'h00A5);
        @(negedge clk);
        ad_lo = 8'hFF;
        #2;
        check("R2 held while data", {8'h00, addr[7:0]}, 16'h00A5);
        check("R3 joined address", addr, 16'h12A5);
        @(negedge clk);
        ale   = 1'b1;
        ad_lo = 8'h07;
        #2;
        check("R1 transparent again", {8'h00, addr[7:0]}, 16'h0007);

        // sweep: every mode pair, high byte and strobe pattern
        for (int m = 0; m < 4; m++) begin
            for (int h = 0; h < 256; h++) begin
                for (int s = 0; s < 8; s++) begin
                    @(negedge clk);
                    shared_rom = m[0];
                    win_mode   = m[1];
                    a_hi       = h[7:0];
                    ad_lo      = h[7:0] ^ 8'h5A;
                    {psen_n, rd_n, wr_n} = s[2:0];
                    #2;
                    shr  = m[0];
                    win  = m[1];
                    bank = h[7:6];
                    code = !s[2];
                    data = s[2] && (!s[1] || !s[0]);
                    // order: prom, drom, dram, win (active high here)
                    exp_sel[3] = code || (data && !win && shr && bank == 2'b00);
                    exp_sel[2] = data && !win && !shr && bank == 2'b00;
                    exp_sel[1] = data && !win && bank == 2'b10;
                    exp_sel[0] = data && win && h[7:4] == 4'b0011;
                    // order: prom_oe_n, mem_oe_n, mem_we_n
                    exp_en[2] = shr ? (s[2] & s[1]) : s[2];
                    exp_en[1] = s[1];
                    exp_en[0] = !(!s[0] && (exp_sel[1] || exp_sel[0]));
                    check("R1 R3 address", addr, {h[7:0], h[7:0] ^ 8'h5A});
                    check("R4 R5 R6 R8 R9 R11 selects",
                          {12'h0, ~prom_cs_n, ~drom_cs_n, ~dram_cs_n, ~win_cs_n},
                          {12'h0, exp_sel});
                    check("R7 R8 R10 enables",
                          {13'h0, prom_oe_n, mem_oe_n, mem_we_n},
                          {13'h0, exp_en});
                end
            end
        end
        @(negedge clk);
        finish_run();
    end
endmodule